// File: doc/BRIEF.md
# Predicated SIMD Divergence Execution Core

This block executes one instruction stream over a 16-element data vector. Each element owns a small private register file. The arithmetic is done by eight physical lanes, so every vector arithmetic instruction runs in two passes. The first pass covers elements 0 to 7 and the second covers elements 8 to 15. A single decoded instruction drives both passes.

Branches are handled by predication. Each element carries one bit in an active mask, and only active elements have their results written. A branch instruction carries a per-element condition vector. It narrows the mask to the elements that take the branch and saves the enclosing mask on a small stack. An else instruction switches to the complementary group of the saved parent. An endif restores the parent. When all elements agree on a condition, the other path has an empty mask and costs no extra passes. Nested branches can split a group again, down to a single element.

A sequencer feeds one instruction per cycle while `busy` is low. It can read any element's register through the debug read port.

Top module: `simd_pred_core`

## Requirements
- R1: After reset, every register of every element holds 0. The active mask is 16'hFFFF, the stack depth is 0, and `busy` and `ovf_err` are both 0.
- R2: An arithmetic instruction (op code 1) is accepted when `in_valid` is 1, `busy` is 0 and the active mask is non-zero. Elements 0–7 are written at the end of the accepting cycle, with `wb_valid`=1 and `wb_hi`=0. In the next cycle `busy`=1, `wb_valid`=1 and `wb_hi`=1, and elements 8–15 are written at the end of that cycle. `busy` is never high for two cycles in a row.
- R3: The arithmetic function field selects the result for element e from a = reg[rs] of that element. Code 0 gives a+imm, code 1 gives a−imm, code 2 gives a XOR imm, and code 3 gives imm+e. All results are taken modulo 2^W and written to reg[rd].
- R4: An arithmetic instruction writes only the elements whose active-mask bit is 1. Every other element keeps its value.
- R5: Any instruction presented while `busy` is 1 is ignored. Registers, mask and stack do not change.
- R6: A branch (op code 2) pushes the current mask and sets the mask to (mask AND `in_cond`). If every active element has its condition bit set, the mask is left unchanged.
- R7: An else (op code 3) sets the mask to parent AND NOT (parent AND cond), using the values saved by the innermost open branch.
- R8: An endif (op code 4) pops the innermost entry and restores its parent mask. Branches nest to the full stack depth (DEPTH=4), and a nested branch can narrow the mask down to a single element.
- R9: An arithmetic instruction accepted while the mask is all zero writes nothing and does not raise `busy`.
- R10: A branch issued when the stack already holds DEPTH entries sets `ovf_err`, which stays at 1 until reset. The mask and the stack are left unchanged.
- R11: An else or endif issued with an empty stack has no effect on the mask, the stack or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 3 | 0 nop, 1 arithmetic, 2 branch, 3 else, 4 endif |
| in_fn | input | 2 | Arithmetic function code |
| in_rd | input | RW | Destination register |
| in_rs | input | RW | Source register |
| in_imm | input | W | Immediate operand |
| in_cond | input | 16 | Per-element branch condition |
| busy | output | 1 | Second pass in progress; input not accepted |
| wb_valid | output | 1 | A pass writes back this cycle |
| wb_hi | output | 1 | 0: elements 0–7, 1: elements 8–15 |
| wb_rd | output | RW | Destination register of the pass |
| wb_en | output | 8 | Per-lane write enable (masked) |
| wb_data | output | 8*W | Lane results, lane 0 in the low bits |
| active_mask | output | 16 | Current active mask |
| stack_depth | output | DW | Open branch levels |
| ovf_err | output | 1 | Sticky stack overflow flag |
| dbg_elem | input | 4 | Debug read element |
| dbg_reg | input | RW | Debug read register |
| dbg_data | output | W | Debug read data |

## Verification
The bench sweeps all four arithmetic functions over several immediates, including wrap-around values. Here a lane given the wrong element index or carry width would corrupt the upper half. It opens a divergent branch on each single element in turn. A design that mixed up the else mask would write the wrong group, or write the isolated element twice. It nests branches to full depth, then overflows and unwinds, and issues else and endif on an empty stack. A faulty stack would restore the wrong parent or lose the mask. Junk instructions are held on the input during every busy cycle, so a design that accepted input in the second pass would change the mask or the registers.

// File: rtl/simd_pred_pkg.sv
package simd_pred_pkg;

    localparam int ELEMS = 16;
    localparam int LANES = 8;
    localparam int PASSES = ELEMS / LANES;

    typedef logic [ELEMS-1:0] mask_t;
    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ALU   = 3'd1,
        OP_IF    = 3'd2,
        OP_ELSE  = 3'd3,
        OP_ENDIF = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_XOR = 2'd2,
        FN_LDI = 2'd3
    } fn_e;

    typedef struct packed {
        mask_t parent;
        mask_t taken;
    } frame_t;

    function automatic lane_mask_t half_of(input mask_t m, input logic hi);
        return hi ? m[ELEMS-1:LANES] : m[LANES-1:0];
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pred_pkg::*;
#(
    parameter int W       = 8,
    parameter int LANE_ID = 0
) (
    input  fn_e          fn,
    input  logic         hi,
    input  logic [W-1:0] a,
    input  logic [W-1:0] imm,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] IDX_LO = W'(LANE_ID);
    localparam logic [W-1:0] IDX_HI = W'(LANE_ID + LANES);

    logic [W-1:0] idx;

    always_comb begin
        idx = hi ? IDX_HI : IDX_LO;
        case (fn)
            FN_ADD:  res = a + imm;
            FN_SUB:  res = a - imm;
            FN_XOR:  res = a ^ imm;
            default: res = imm + idx;
        endcase
    end
endmodule

// File: rtl/simd_regfile.sv
module simd_regfile
    import simd_pred_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = 4,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hi,
    input  logic [RW-1:0]       rs,
    output logic [LANES*W-1:0]  rdata,
    input  lane_mask_t          wen,
    input  logic [RW-1:0]       rd,
    input  logic [LANES*W-1:0]  wdata,
    input  logic [3:0]          dbg_elem,
    input  logic [RW-1:0]       dbg_reg,
    output logic [W-1:0]        dbg_data
);
    logic [W-1:0] mem [ELEMS][NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ELEMS; e++)
                for (int r = 0; r < NREG; r++)
                    mem[e][r] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (wen[l])
                    mem[(hi ? LANES : 0) + l][rd] <= wdata[l*W +: W];
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++)
            rdata[l*W +: W] = mem[(hi ? LANES : 0) + l][rs];
        dbg_data = mem[dbg_elem][dbg_reg];
    end
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
    import simd_pred_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  frame_t        push_frame,
    output frame_t        top,
    output logic          empty,
    output logic          full,
    output logic [DW-1:0] depth
);
    frame_t        frames [DEPTH];
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) frames[i] <= '0;
        end else if (push) begin
            frames[cnt] <= push_frame;
            cnt         <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == DW'(DEPTH));
        depth = cnt;
        top   = empty ? '0 : frames[cnt - 1'b1];
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R10
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R11
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (cnt == $past(cnt) - 1'b1)); // R8
endmodule

// File: rtl/simd_pred_core.sv
module simd_pred_core
    import simd_pred_pkg::*;
#(
    parameter int W     = 8,
    parameter int NREG  = 4,
    parameter int DEPTH = 4,
    localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         in_op,
    input  logic [1:0]         in_fn,
    input  logic [RW-1:0]      in_rd,
    input  logic [RW-1:0]      in_rs,
    input  logic [W-1:0]       in_imm,
    input  logic [15:0]        in_cond,
    output logic               busy,
    output logic               wb_valid,
    output logic               wb_hi,
    output logic [RW-1:0]      wb_rd,
    output logic [7:0]         wb_en,
    output logic [8*W-1:0]     wb_data,
    output logic [15:0]        active_mask,
    output logic [DW-1:0]      stack_depth,
    output logic               ovf_err,
    input  logic [3:0]         dbg_elem,
    input  logic [RW-1:0]      dbg_reg,
    output logic [W-1:0]       dbg_data
);
    // second-pass state
    logic          pass2_q;
    fn_e           fn_q;
    logic [RW-1:0] rd_q, rs_q;
    logic [W-1:0]  imm_q;

    mask_t active_q;
    logic  ovf_q;

    op_e   op;
    logic  accept, alu_go, if_go, else_go, endif_go, push, pop;
    frame_t top_frame, new_frame;
    logic  stk_empty, stk_full;

    fn_e           cur_fn;
    logic [RW-1:0] cur_rd, cur_rs;
    logic [W-1:0]  cur_imm;
    logic [LANES*W-1:0] lane_a, lane_res;
    lane_mask_t    lane_wen;

    always_comb begin
        op       = op_e'(in_op);
        accept   = in_valid && !pass2_q;
        alu_go   = accept && (op == OP_ALU) && (active_q != '0);
        if_go    = accept && (op == OP_IF);
        else_go  = accept && (op == OP_ELSE) && !stk_empty;
        endif_go = accept && (op == OP_ENDIF) && !stk_empty;
        push     = if_go && !stk_full;
        pop      = endif_go;
        new_frame.parent = active_q;
        new_frame.taken  = active_q & in_cond;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass2_q  <= 1'b0;
            fn_q     <= FN_ADD;
            rd_q     <= '0;
            rs_q     <= '0;
            imm_q    <= '0;
            active_q <= '1;
            ovf_q    <= 1'b0;
        end else begin
            pass2_q <= alu_go;
            if (alu_go) begin
                fn_q  <= fn_e'(in_fn);
                rd_q  <= in_rd;
                rs_q  <= in_rs;
                imm_q <= in_imm;
            end
            if (if_go && stk_full)
                ovf_q <= 1'b1;
            else if (push)
                active_q <= new_frame.taken;
            else if (else_go)
                active_q <= top_frame.parent & ~top_frame.taken;
            else if (endif_go)
                active_q <= top_frame.parent;
        end
    end

    // pass selection: first pass from the inputs, second from the latch
    always_comb begin
        cur_fn   = pass2_q ? fn_q  : fn_e'(in_fn);
        cur_rd   = pass2_q ? rd_q  : in_rd;
        cur_rs   = pass2_q ? rs_q  : in_rs;
        cur_imm  = pass2_q ? imm_q : in_imm;
        wb_valid = alu_go || pass2_q;
        lane_wen = wb_valid ? half_of(active_q, pass2_q) : '0;
    end

    simd_mask_stack #(.DEPTH(DEPTH)) i_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .push_frame (new_frame),
        .top        (top_frame),
        .empty      (stk_empty),
        .full       (stk_full),
        .depth      (stack_depth)
    );

    simd_regfile #(.W(W), .NREG(NREG)) i_rf (
        .clk      (clk),
        .rst      (rst),
        .hi       (pass2_q),
        .rs       (cur_rs),
        .rdata    (lane_a),
        .wen      (lane_wen),
        .rd       (cur_rd),
        .wdata    (lane_res),
        .dbg_elem (dbg_elem),
        .dbg_reg  (dbg_reg),
        .dbg_data (dbg_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        simd_lane #(.W(W), .LANE_ID(l)) i_lane (
            .fn  (cur_fn),
            .hi  (pass2_q),
            .a   (lane_a[l*W +: W]),
            .imm (cur_imm),
            .res (lane_res[l*W +: W])
        );
    end

    assign busy        = pass2_q;
    assign wb_hi       = pass2_q;
    assign wb_rd       = cur_rd;
    assign wb_en       = lane_wen;
    assign wb_data     = lane_res;
    assign active_mask = active_q;
    assign ovf_err     = ovf_q;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R2
    AST_BUSY_FOLLOWS_WB: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(wb_valid && !wb_hi)); // R2
    AST_BUSY_FREEZES_MASK: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(active_mask)); // R5
    AST_IF_NARROWS: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !busy && in_op == 3'd2)
            |-> ((active_mask & ~$past(active_mask)) == '0)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R10
    AST_ZERO_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (active_mask == '0) |-> (wb_en == '0)); // R9
endmodule

// File: tb/test_simd_pred_core.sv
module test_simd_pred_core;
    localparam int W = 8, NREG = 4, DEPTH = 4, RW = 2, DW = 3;

    logic clk = 0, rst = 1;
    logic in_valid = 0;
    logic [2:0] in_op = 0;
    logic [1:0] in_fn = 0;
    logic [RW-1:0] in_rd = 0, in_rs = 0;
    logic [W-1:0] in_imm = 0;
    logic [15:0] in_cond = 0;
    logic busy, wb_valid, wb_hi, ovf_err;
    logic [RW-1:0] wb_rd;
    logic [7:0] wb_en;
    logic [8*W-1:0] wb_data;
    logic [15:0] active_mask;
    logic [DW-1:0] stack_depth;
    logic [3:0] dbg_elem = 0;
    logic [RW-1:0] dbg_reg = 0;
    logic [W-1:0] dbg_data;

    int errors = 0, checks = 0;

    // bench model
    logic [W-1:0] mrf [16][NREG];
    logic [15:0] mmask, mpar [DEPTH], mtak [DEPTH];
    int mdep;
    logic movf;

    always #5 clk = ~clk;

    simd_pred_core #(.W(W), .NREG(NREG), .DEPTH(DEPTH)) i_simd_pred_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_fn(in_fn),
        .in_rd(in_rd), .in_rs(in_rs), .in_imm(in_imm), .in_cond(in_cond),
        .busy(busy), .wb_valid(wb_valid), .wb_hi(wb_hi), .wb_rd(wb_rd),
        .wb_en(wb_en), .wb_data(wb_data), .active_mask(active_mask),
        .stack_depth(stack_depth), .ovf_err(ovf_err), .dbg_elem(dbg_elem),
        .dbg_reg(dbg_reg), .dbg_data(dbg_data));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fexp(input int fn, input logic [W-1:0] a,
                                          input logic [W-1:0] imm, input int e);
        case (fn)
            0: return a + imm;
            1: return a - imm;
            2: return a ^ imm;
            default: return imm + W'(e);
        endcase
    endfunction

    task automatic check_all(input string req);
        for (int e = 0; e < 16; e++)
            for (int r = 0; r < NREG; r++) begin
                dbg_elem = 4'(e); dbg_reg = RW'(r);
                #1;
                chk(req, 32'(dbg_data), 32'(mrf[e][r]));
            end
        chk(req, 32'(active_mask), 32'(mmask));
        chk(req, 32'(stack_depth), 32'(mdep));
        chk(req, 32'(ovf_err), 32'(movf));
    endtask

    task automatic issue(input logic [2:0] op, input int fn, input int rd, input int rs,
                         input logic [W-1:0] imm, input logic [15:0] cond);
        logic two;
        @(negedge clk);
        in_valid = 1; in_op = op; in_fn = 2'(fn); in_rd = RW'(rd); in_rs = RW'(rs);
        in_imm = imm; in_cond = cond;
        two = (op == 3'd1) && (mmask != 0);
        @(posedge clk); #1;
        if (two) begin
            chk("R2 busy in second pass", 32'(busy), 1);
            // junk held during busy: a branch that would clear the mask (R5)
            in_op = 3'd2; in_cond = 16'h0000; in_rd = RW'(rd + 1);
            @(posedge clk); #1;
        end
        chk(op == 3'd1 ? "R9 busy after op" : "R2 busy low", 32'(busy), 0);
        in_valid = 0; in_op = 0;
        // model update
        case (op)
            3'd1: for (int e = 0; e < 16; e++)
                      if (mmask[e]) mrf[e][rd] = fexp(fn, mrf[e][rs], imm, e);
            3'd2: if (mdep == DEPTH) movf = 1;
                  else begin
                      mpar[mdep] = mmask; mtak[mdep] = mmask & cond;
                      mmask = mmask & cond; mdep++;
                  end
            3'd3: if (mdep > 0) mmask = mpar[mdep-1] & ~mtak[mdep-1];
            3'd4: if (mdep > 0) begin mmask = mpar[mdep-1]; mdep--; end
            default: ;
        endcase
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] imms [5];
        imms[0] = 0; imms[1] = 1; imms[2] = 8'h7f; imms[3] = 8'hff; imms[4] = 8'h80;
        for (int e = 0; e < 16; e++) for (int r = 0; r < NREG; r++) mrf[e][r] = 0;
        mmask = 16'hffff; mdep = 0; movf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 busy", 32'(busy), 0);
        check_all("R1 reset state");

        // R2 timing of the two passes, R5 input ignored in busy
        @(negedge clk);
        in_valid = 1; in_op = 3'd1; in_fn = 2'd3; in_rd = 0; in_rs = 0; in_imm = 8'd5;
        #1;
        chk("R2 first pass wb_valid", 32'(wb_valid), 1);
        chk("R2 first pass wb_hi", 32'(wb_hi), 0);
        chk("R2 first pass lane3 data", 32'(wb_data[3*W +: W]), 8);
        @(posedge clk); #1;
        in_op = 3'd2; in_cond = 16'h0000;
        dbg_reg = 0; dbg_elem = 3; #1;
        chk("R2 low half written after first edge", 32'(dbg_data), 8);
        dbg_elem = 12; #1;
        chk("R2 high half not yet written", 32'(dbg_data), 0);
        chk("R2 busy", 32'(busy), 1);
        chk("R2 second pass wb_hi", 32'(wb_hi), 1);
        chk("R2 second pass wb_en", 32'(wb_en), 32'hff);
        @(posedge clk); #1;
        in_valid = 0; in_op = 0;
        chk("R2 busy drops", 32'(busy), 0);
        for (int e = 0; e < 16; e++) mrf[e][0] = 8'(5 + e);
        check_all("R5 junk during busy ignored");

        // R3 sweep of functions and immediates
        for (int fn = 0; fn < 4; fn++)
            for (int k = 0; k < 5; k++) begin
                issue(3'd1, fn, (fn + k) % NREG, k % NREG, imms[k], 0);
                check_all("R3 function sweep");
            end

        // R6 uniform branch, R9 empty else path
        issue(3'd2, 0, 0, 0, 0, 16'hffff);
        chk("R6 uniform mask", 32'(active_mask), 32'hffff);
        issue(3'd1, 0, 1, 1, 8'd3, 0);
        issue(3'd3, 0, 0, 0, 0, 0);
        chk("R7 empty else mask", 32'(active_mask), 0);
        issue(3'd1, 3, 2, 0, 8'd99, 0);
        check_all("R9 zero-mask op writes nothing");
        issue(3'd4, 0, 0, 0, 0, 0);
        check_all("R8 endif restore");

        // R4 R7 divergence on each single element
        for (int e = 0; e < 16; e++) begin
            issue(3'd2, 0, 0, 0, 0, 16'(1 << e));
            issue(3'd1, 0, 1, 1, 8'd1, 0);
            issue(3'd3, 0, 0, 0, 0, 0);
            chk("R7 else mask", 32'(active_mask), 32'(16'hffff & ~(16'(1 << e))));
            issue(3'd1, 2, 2, 2, 8'(e + 1), 0);
            issue(3'd4, 0, 0, 0, 0, 0);
            check_all("R4 masked divergent writes");
        end

        // R8 nesting to a single element, R10 overflow, unwinding
        issue(3'd2, 0, 0, 0, 0, 16'h00ff);
        issue(3'd1, 0, 3, 3, 8'd1, 0);
        issue(3'd2, 0, 0, 0, 0, 16'h0f0f);
        issue(3'd1, 0, 3, 3, 8'd2, 0);
        issue(3'd2, 0, 0, 0, 0, 16'h3333);
        issue(3'd1, 0, 3, 3, 8'd4, 0);
        issue(3'd2, 0, 0, 0, 0, 16'h5555);
        chk("R8 single element mask", 32'(active_mask), 32'h0001);
        issue(3'd1, 0, 3, 3, 8'd8, 0);
        check_all("R8 nested writes");
        issue(3'd2, 0, 0, 0, 0, 16'h0000);
        chk("R10 overflow flag", 32'(ovf_err), 1);
        check_all("R10 overflow leaves state");
        issue(3'd3, 0, 0, 0, 0, 0);
        chk("R7 nested else mask", 32'(active_mask), 32'h0002);
        issue(3'd1, 3, 0, 0, 8'd50, 0);
        for (int i = 0; i < 4; i++) begin
            issue(3'd4, 0, 0, 0, 0, 0);
            check_all("R8 unwind");
        end
        chk("R8 full restore", 32'(active_mask), 32'hffff);

        // R11 else/endif on empty stack
        issue(3'd3, 0, 0, 0, 0, 0);
        issue(3'd4, 0, 0, 0, 0, 0);
        check_all("R11 empty stack ignored");
        issue(3'd1, 1, 0, 0, 8'd1, 0);
        check_all("R11 full width after empty endif");
        chk("R10 overflow sticky", 32'(ovf_err), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule